// File: doc/BRIEF.md
# Multi-Core Register Access Partitioner

This block stands between several processor cores and the register file of a display controller. Each request carries the ID of the core that issued it. The block decodes the address into one resource region: a per-core common area, the single global configuration area, a video pipeline, a video port, or the overlay manager tied to a port. It then checks the request against an ownership table. Permitted reads and writes reach the register file. A refused write is dropped. A refused read returns zero. Both carry an error status.

The ownership table holds the owner of each common area, the global area, each pipeline and each port, plus the port each pipeline is routed to. A privileged configuration port loads the table until a lock bit is set. A video port is writable only by its owner. Any core that owns a pipeline routed to that port may also read it. An overlay manager follows the rights of its port. Each core has a sticky violation record. It holds the address of that core's first refused access until the core clears it.

Top module: `regpart_guard`

## Requirements
- R1: Address bits [8:4] select a region and bits [3:0] a word inside it. Regions 0-3 are the common areas, 4 is the global area, 5-8 are pipelines 0-3, 9-12 are ports 0-3 and 13-16 are overlay managers 0-3. Common area i is readable and writable only by the core entered as its owner (core i after reset). Any other core is refused.
- R2: The global area is readable and writable only by its single owner (core 0 after reset). All other cores are refused.
- R3: Pipeline i can be read and written only by its owner (core i after reset). Reads and writes from any other core are refused.
- R4: The owner of video port v (core v after reset) may read and write that port's region.
- R5: A core that does not own port v may read it only if it owns a pipeline currently routed to v (pipeline i routes to port i after reset). Its writes to the port are refused. Every other core is refused both reads and writes.
- R6: Overlay manager v grants exactly the rights of port v, changing whenever the port owner or the routing changes.
- R7: A response follows each request one cycle later with rsp_valid high. Status 2'b00 means accepted, 2'b10 means refused. A refused write leaves the stored word unchanged. A refused read, and every write, returns zero data. An accepted read returns the last accepted write to that word, or zero after reset.
- R8: An address in regions 17-31 answers with status 2'b11, zero data, and no storage change.
- R9: While unlocked, a configuration write sets one table entry. cfg_kind selects the entry: 0 common owner, 1 global owner, 2 pipeline owner, 3 pipeline route, 4 port owner. cfg_idx gives the index and cfg_val the value. A pulse on cfg_lock sets cfg_locked, which stays set until reset, and every later configuration write is ignored.
- R10: When a core is refused (status 2'b10), its viol_flag bit rises in the response cycle. Its viol_addr slice (bits c*9 and up) captures the refused address if the flag was clear. Later refusals leave it unchanged. Decode errors are not recorded. A viol_clr pulse with viol_clr_core = c clears core c's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request present |
| req_core | input | 2 | Requesting core ID |
| req_addr | input | 9 | Word address: region and offset |
| req_we | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_status | output | 2 | 00 accepted, 10 refused, 11 decode error |
| rsp_rdata | output | 32 | Read data, zero unless an accepted read |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_kind | input | 3 | Table entry kind |
| cfg_idx | input | 2 | Entry index |
| cfg_val | input | 2 | Entry value: a core ID or a port number |
| cfg_lock | input | 1 | Lock request pulse |
| cfg_locked | output | 1 | Table is frozen |
| viol_clr | input | 1 | Violation record clear strobe |
| viol_clr_core | input | 2 | Core whose record is cleared |
| viol_flag | output | 4 | Per-core sticky violation flag |
| viol_addr | output | 36 | Per-core first refused address, 9 bits per core |

## Verification
The hardest case is read-only sharing of a port by a core that owns a pipeline routed there. That core must not own the port itself, and the routing and ownership must first be changed away from their reset pattern. The bench therefore reprograms the table so that one core owns a pipeline routed to another core's port, and one port has two sharing readers. It also gives a core a pipeline routed to its own port. It then locks the table, tries to overwrite it, and repeats the full sweep of every core, region and direction. Each status and read word is compared against a table model and a shadow memory kept in the bench.

// File: rtl/regpart_pkg.sv
package regpart_pkg;

   typedef enum logic [1:0] {
      ST_OKAY   = 2'b00,
      ST_SLVERR = 2'b10,
      ST_DECERR = 2'b11
   } rsp_st_e;

   typedef enum logic [2:0] {
      CK_COMMON_OWN = 3'd0,
      CK_GLOBAL_OWN = 3'd1,
      CK_PIPE_OWN   = 3'd2,
      CK_PIPE_ROUTE = 3'd3,
      CK_PORT_OWN   = 3'd4
   } cfg_kind_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/regpart_cfg.sv
module regpart_cfg
   import regpart_pkg::*;
#(
   parameter int N_CORES  = 4,
   parameter int N_COMMON = 4,
   parameter int N_PIPES  = 4,
   parameter int N_PORTS  = 4,
   parameter int CORE_W   = $clog2(N_CORES),
   parameter int PORT_W   = $clog2(N_PORTS),
   parameter int IDX_W    = $clog2(max3(N_COMMON, N_PIPES, N_PORTS)),
   parameter int VAL_W    = (CORE_W > PORT_W) ? CORE_W : PORT_W
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               cfg_we,
   input  logic [2:0]                         cfg_kind,
   input  logic [IDX_W-1:0]                   cfg_idx,
   input  logic [VAL_W-1:0]                   cfg_val,
   input  logic                               cfg_lock,
   output logic                               locked,
   output logic [N_COMMON-1:0][CORE_W-1:0]    common_own,
   output logic [CORE_W-1:0]                  global_own,
   output logic [N_PIPES-1:0][CORE_W-1:0]     pipe_own,
   output logic [N_PIPES-1:0][PORT_W-1:0]     pipe_route,
   output logic [N_PORTS-1:0][CORE_W-1:0]     port_own
);

   logic wr_ok;
   assign wr_ok = cfg_we && !locked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= 1'b0;
      end else if (cfg_lock) begin
         locked <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         global_own <= '0;
      end else if (wr_ok && cfg_kind == CK_GLOBAL_OWN) begin
         global_own <= cfg_val[CORE_W-1:0];
      end
   end

   for (genvar i = 0; i < N_COMMON; i++) begin : g_common
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            common_own[i] <= CORE_W'(i % N_CORES);
         end else if (wr_ok && cfg_kind == CK_COMMON_OWN && cfg_idx == IDX_W'(i)) begin
            common_own[i] <= cfg_val[CORE_W-1:0];
         end
      end
   end

   for (genvar i = 0; i < N_PIPES; i++) begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pipe_own[i]   <= CORE_W'(i % N_CORES);
            pipe_route[i] <= PORT_W'(i % N_PORTS);
         end else if (wr_ok && cfg_idx == IDX_W'(i)) begin
            if (cfg_kind == CK_PIPE_OWN)   pipe_own[i]   <= cfg_val[CORE_W-1:0];
            if (cfg_kind == CK_PIPE_ROUTE) pipe_route[i] <= cfg_val[PORT_W-1:0];
         end
      end
   end

   for (genvar i = 0; i < N_PORTS; i++) begin : g_port
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            port_own[i] <= CORE_W'(i % N_CORES);
         end else if (wr_ok && cfg_kind == CK_PORT_OWN && cfg_idx == IDX_W'(i)) begin
            port_own[i] <= cfg_val[CORE_W-1:0];
         end
      end
   end

endmodule

// File: rtl/regpart_decide.sv
module regpart_decide #(
   parameter int N_CORES  = 4,
   parameter int N_COMMON = 4,
   parameter int N_PIPES  = 4,
   parameter int N_PORTS  = 4,
   parameter int OFS_W    = 4,
   parameter int CORE_W   = $clog2(N_CORES),
   parameter int PORT_W   = $clog2(N_PORTS),
   parameter int N_REG    = N_COMMON + 1 + N_PIPES + 2 * N_PORTS,
   parameter int RIDX_W   = $clog2(N_REG),
   parameter int ADDR_W   = RIDX_W + OFS_W
) (
   input  logic [CORE_W-1:0]                  core,
   input  logic [ADDR_W-1:0]                  addr,
   input  logic                               we,
   input  logic [N_COMMON-1:0][CORE_W-1:0]    common_own,
   input  logic [CORE_W-1:0]                  global_own,
   input  logic [N_PIPES-1:0][CORE_W-1:0]     pipe_own,
   input  logic [N_PIPES-1:0][PORT_W-1:0]     pipe_route,
   input  logic [N_PORTS-1:0][CORE_W-1:0]     port_own,
   output logic                               hit,
   output logic                               allow
);

   localparam int GLOBAL_BASE = N_COMMON;
   localparam int PIPE_BASE   = GLOBAL_BASE + 1;
   localparam int PORT_BASE   = PIPE_BASE + N_PIPES;
   localparam int OVL_BASE    = PORT_BASE + N_PORTS;

   logic [RIDX_W-1:0]  ridx;
   logic [N_PORTS-1:0] share;

   assign ridx = addr[ADDR_W-1:OFS_W];

   // read sharing: requester owns some pipeline routed to the port
   for (genvar v = 0; v < N_PORTS; v++) begin : g_share
      logic [N_PIPES-1:0] feeds;
      for (genvar p = 0; p < N_PIPES; p++) begin : g_feed
         assign feeds[p] = (pipe_own[p] == core) && (pipe_route[p] == PORT_W'(v));
      end
      assign share[v] = |feeds;
   end

   always_comb begin
      hit   = 1'b0;
      allow = 1'b0;
      for (int i = 0; i < N_COMMON; i++) begin
         if (ridx == RIDX_W'(i)) begin
            hit   = 1'b1;
            allow = (common_own[i] == core);
         end
      end
      if (ridx == RIDX_W'(GLOBAL_BASE)) begin
         hit   = 1'b1;
         allow = (global_own == core);
      end
      for (int i = 0; i < N_PIPES; i++) begin
         if (ridx == RIDX_W'(PIPE_BASE + i)) begin
            hit   = 1'b1;
            allow = (pipe_own[i] == core);
         end
      end
      for (int i = 0; i < N_PORTS; i++) begin
         if (ridx == RIDX_W'(PORT_BASE + i) || ridx == RIDX_W'(OVL_BASE + i)) begin
            hit   = 1'b1;
            allow = (port_own[i] == core) || (!we && share[i]);
         end
      end
   end

endmodule

// File: rtl/regpart_bank.sv
module regpart_bank #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 9,
   parameter int DEPTH  = 272
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         rdata <= '0;
      end else begin
         if (wr_en) mem[addr] <= wdata;
         if (rd_en) rdata <= mem[addr];
      end
   end

endmodule

// File: rtl/regpart_viol.sv
module regpart_viol #(
   parameter int N_CORES = 4,
   parameter int ADDR_W  = 9,
   parameter int CORE_W  = $clog2(N_CORES)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        deny,
   input  logic [CORE_W-1:0]           deny_core,
   input  logic [ADDR_W-1:0]           deny_addr,
   input  logic                        clr,
   input  logic [CORE_W-1:0]           clr_core,
   output logic [N_CORES-1:0]          flag,
   output logic [N_CORES*ADDR_W-1:0]   addr_rec
);

   for (genvar c = 0; c < N_CORES; c++) begin : g_core
      logic hit_c, clr_c;
      assign hit_c = deny && (deny_core == CORE_W'(c));
      assign clr_c = clr && (clr_core == CORE_W'(c));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag[c]                    <= 1'b0;
            addr_rec[c*ADDR_W +: ADDR_W] <= '0;
         end else if (hit_c && (!flag[c] || clr_c)) begin
            flag[c]                    <= 1'b1;
            addr_rec[c*ADDR_W +: ADDR_W] <= deny_addr;
         end else if (clr_c) begin
            flag[c] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/regpart_guard.sv
module regpart_guard
   import regpart_pkg::*;
#(
   parameter int N_CORES  = 4,
   parameter int N_COMMON = 4,
   parameter int N_PIPES  = 4,
   parameter int N_PORTS  = 4,
   parameter int OFS_W    = 4,
   parameter int DATA_W   = 32,
   localparam int CORE_W  = $clog2(N_CORES),
   localparam int PORT_W  = $clog2(N_PORTS),
   localparam int N_REG   = N_COMMON + 1 + N_PIPES + 2 * N_PORTS,
   localparam int RIDX_W  = $clog2(N_REG),
   localparam int ADDR_W  = RIDX_W + OFS_W,
   localparam int IDX_W   = $clog2(max3(N_COMMON, N_PIPES, N_PORTS)),
   localparam int VAL_W   = (CORE_W > PORT_W) ? CORE_W : PORT_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic [CORE_W-1:0]         req_core,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic                      req_we,
   input  logic [DATA_W-1:0]         req_wdata,
   output logic                      rsp_valid,
   output logic [1:0]                rsp_status,
   output logic [DATA_W-1:0]         rsp_rdata,
   input  logic                      cfg_we,
   input  logic [2:0]                cfg_kind,
   input  logic [IDX_W-1:0]          cfg_idx,
   input  logic [VAL_W-1:0]          cfg_val,
   input  logic                      cfg_lock,
   output logic                      cfg_locked,
   input  logic                      viol_clr,
   input  logic [CORE_W-1:0]         viol_clr_core,
   output logic [N_CORES-1:0]        viol_flag,
   output logic [N_CORES*ADDR_W-1:0] viol_addr
);

   localparam int DEPTH = N_REG << OFS_W;

   if (N_CORES < 2)                 begin : g_bad_cores  $error("N_CORES must be at least 2");  end
   if (N_PORTS < 2)                 begin : g_bad_ports  $error("N_PORTS must be at least 2");  end
   if (N_COMMON < 1 || N_PIPES < 1) begin : g_bad_count  $error("region counts must be >= 1"); end
   if (DATA_W < 1)                  begin : g_bad_data   $error("DATA_W must be positive");     end

   logic [N_COMMON-1:0][CORE_W-1:0] common_own;
   logic [CORE_W-1:0]               global_own;
   logic [N_PIPES-1:0][CORE_W-1:0]  pipe_own;
   logic [N_PIPES-1:0][PORT_W-1:0]  pipe_route;
   logic [N_PORTS-1:0][CORE_W-1:0]  port_own;
   logic                            hit, allow;
   logic                            rd_ok_q;
   logic [DATA_W-1:0]               bank_rdata;
   rsp_st_e                         st_now;

   regpart_cfg #(
      .N_CORES(N_CORES), .N_COMMON(N_COMMON), .N_PIPES(N_PIPES), .N_PORTS(N_PORTS)
   ) i_cfg (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_val(cfg_val),
      .cfg_lock(cfg_lock), .locked(cfg_locked),
      .common_own(common_own), .global_own(global_own),
      .pipe_own(pipe_own), .pipe_route(pipe_route), .port_own(port_own)
   );

   regpart_decide #(
      .N_CORES(N_CORES), .N_COMMON(N_COMMON), .N_PIPES(N_PIPES), .N_PORTS(N_PORTS),
      .OFS_W(OFS_W)
   ) i_decide (
      .core(req_core), .addr(req_addr), .we(req_we),
      .common_own(common_own), .global_own(global_own),
      .pipe_own(pipe_own), .pipe_route(pipe_route), .port_own(port_own),
      .hit(hit), .allow(allow)
   );

   always_comb begin
      if (!hit)       st_now = ST_DECERR;
      else if (allow) st_now = ST_OKAY;
      else            st_now = ST_SLVERR;
   end

   regpart_bank #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)
   ) i_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(req_valid && st_now == ST_OKAY && req_we),
      .rd_en(req_valid && st_now == ST_OKAY && !req_we),
      .addr(req_addr), .wdata(req_wdata), .rdata(bank_rdata)
   );

   regpart_viol #(
      .N_CORES(N_CORES), .ADDR_W(ADDR_W)
   ) i_viol (
      .clk(clk), .rst_n(rst_n),
      .deny(req_valid && st_now == ST_SLVERR),
      .deny_core(req_core), .deny_addr(req_addr),
      .clr(viol_clr), .clr_core(viol_clr_core),
      .flag(viol_flag), .addr_rec(viol_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_status <= ST_OKAY;
         rd_ok_q    <= 1'b0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_status <= req_valid ? st_now : ST_OKAY;
         rd_ok_q    <= req_valid && st_now == ST_OKAY && !req_we;
      end
   end

   assign rsp_rdata = rd_ok_q ? bank_rdata : '0;

endmodule

// File: rtl/regpart_guard_chk.sv
module regpart_guard_chk #(
   parameter int N_CORES = 4,
   parameter int ADDR_W  = 9,
   parameter int OFS_W   = 4,
   parameter int N_REG   = 17,
   parameter int DATA_W  = 32,
   parameter int CORE_W  = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      req_valid,
   input logic [ADDR_W-1:0]         req_addr,
   input logic                      rsp_valid,
   input logic [1:0]                rsp_status,
   input logic [DATA_W-1:0]         rsp_rdata,
   input logic                      cfg_lock,
   input logic                      cfg_locked,
   input logic                      viol_clr,
   input logic [CORE_W-1:0]         viol_clr_core,
   input logic [N_CORES-1:0]        viol_flag,
   input logic [N_CORES*ADDR_W-1:0] viol_addr
);

   // R7
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R7
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R7
   deny_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status != 2'b00) |-> (rsp_rdata == '0));

   // R8
   decerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && int'(req_addr[ADDR_W-1:OFS_W]) >= N_REG) |=> (rsp_status == 2'b11));

   // R9
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_locked |=> cfg_locked);

   // R9
   lock_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_lock |=> cfg_locked);

   for (genvar c = 0; c < N_CORES; c++) begin : g_core
      // R10
      viol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (viol_flag[c] && !(viol_clr && viol_clr_core == CORE_W'(c)))
            |=> (viol_flag[c] && $stable(viol_addr[c*ADDR_W +: ADDR_W])));
   end

endmodule

bind regpart_guard regpart_guard_chk #(
   .N_CORES(N_CORES), .ADDR_W(ADDR_W), .OFS_W(OFS_W), .N_REG(N_REG),
   .DATA_W(DATA_W), .CORE_W(CORE_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
   .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
   .cfg_lock(cfg_lock), .cfg_locked(cfg_locked),
   .viol_clr(viol_clr), .viol_clr_core(viol_clr_core),
   .viol_flag(viol_flag), .viol_addr(viol_addr)
);

// File: tb/test_regpart_guard.sv
module test_regpart_guard;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_core = '0;
   logic [8:0]  req_addr = '0;
   logic        req_we = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [1:0]  rsp_status;
   logic [31:0] rsp_rdata;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_kind = '0;
   logic [1:0]  cfg_idx = '0;
   logic [1:0]  cfg_val = '0;
   logic        cfg_lock = 1'b0;
   logic        cfg_locked;
   logic        viol_clr = 1'b0;
   logic [1:0]  viol_clr_core = '0;
   logic [3:0]  viol_flag;
   logic [35:0] viol_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model of the table
   int m_common[4], m_glob, m_pown[4], m_route[4], m_vown[4];
   logic [31:0] shadow [512];
   bit  m_vf[4];
   int  m_va[4];

   always #5 clk = ~clk;

   regpart_guard i_regpart_guard (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
      .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
      .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_val(cfg_val),
      .cfg_lock(cfg_lock), .cfg_locked(cfg_locked),
      .viol_clr(viol_clr), .viol_clr_core(viol_clr_core),
      .viol_flag(viol_flag), .viol_addr(viol_addr)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int exp_status(input int c, input int r, input bit we);
      if (r < 4)  return (m_common[r] == c) ? 0 : 2;
      if (r == 4) return (m_glob == c) ? 0 : 2;
      if (r < 9)  return (m_pown[r-5] == c) ? 0 : 2;
      if (r < 17) begin
         int v;
         v = (r - 9) % 4;
         if (m_vown[v] == c) return 0;
         if (!we) for (int p = 0; p < 4; p++) if (m_pown[p] == c && m_route[p] == v) return 0;
         return 2;
      end
      return 3;
   endfunction

   function automatic string req_of(input int r);
      if (r < 4)  return "R1";
      if (r == 4) return "R2";
      if (r < 9)  return "R3";
      if (r < 13) return "R4/R5";
      if (r < 17) return "R6";
      return "R8";
   endfunction

   task automatic access(input int c, input int addr, input bit we, input logic [31:0] wd);
      int r, es;
      logic [31:0] ed;
      r  = addr >> 4;
      es = exp_status(c, r, we);
      ed = (es == 0 && !we) ? shadow[addr] : 32'h0;
      @(negedge clk);
      req_valid = 1'b1; req_core = 2'(c); req_addr = 9'(addr); req_we = we; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid == 1'b1, "R7", "rsp_valid", rsp_valid, 1);
      check(rsp_status == 2'(es), req_of(r), $sformatf("status c%0d a%0h we%0d", c, addr, we),
            rsp_status, es);
      check(rsp_rdata == ed, (es == 0) ? req_of(r) : "R7", $sformatf("rdata c%0d a%0h", c, addr),
            rsp_rdata, ed);
      if (es == 0 && we) shadow[addr] = wd;
      if (es == 2 && !m_vf[c]) begin m_vf[c] = 1'b1; m_va[c] = addr; end
   endtask

   task automatic sweep(input int pass);
      for (int c = 0; c < 4; c++) begin
         for (int r = 0; r < 32; r++) begin
            int a;
            a = r * 16 + ((c * 5 + r + pass) % 16);
            access(c, a, 1'b1, 32'hA500_0000 | (pass << 16) | (c << 12) | a);
            access(c, a, 1'b0, 32'h0);
         end
      end
   endtask

   task automatic cfg_write(input int kind, input int idx, input int val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_kind = 3'(kind); cfg_idx = 2'(idx); cfg_val = 2'(val);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic check_viol(input string tag);
      for (int c = 0; c < 4; c++) begin
         check(viol_flag[c] == m_vf[c], "R10", $sformatf("%s flag core%0d", tag, c),
               viol_flag[c], m_vf[c]);
         if (m_vf[c])
            check(viol_addr[c*9 +: 9] == 9'(m_va[c]), "R10", $sformatf("%s addr core%0d", tag, c),
                  viol_addr[c*9 +: 9], m_va[c]);
      end
   endtask

   task automatic clear_core(input int c);
      @(negedge clk);
      viol_clr = 1'b1; viol_clr_core = 2'(c);
      @(negedge clk);
      viol_clr = 1'b0;
      m_vf[c] = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 4; i++) begin
         m_common[i] = i; m_pown[i] = i; m_route[i] = i; m_vown[i] = i; m_vf[i] = 1'b0; m_va[i] = 0;
      end
      m_glob = 0;
      for (int i = 0; i < 512; i++) shadow[i] = 32'h0;

      repeat (3) @(negedge clk);
      check(rsp_valid == 1'b0, "R7", "reset rsp_valid", rsp_valid, 0);
      check(cfg_locked == 1'b0, "R9", "reset cfg_locked", cfg_locked, 0);
      check(viol_flag == 4'h0, "R10", "reset viol_flag", viol_flag, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // default table
      sweep(0);
      check_viol("sweep0");
      for (int c = 0; c < 4; c++) clear_core(c);
      check(viol_flag == 4'h0, "R10", "after clear", viol_flag, 0);

      // reprogram: sharing readers and moved owners (R9)
      cfg_write(1, 0, 2);          // global -> core 2
      cfg_write(0, 0, 3);          // common 0 -> core 3
      cfg_write(0, 3, 0);          // common 3 -> core 0
      cfg_write(2, 1, 3);          // pipe 1 -> core 3
      cfg_write(3, 1, 0);          // pipe 1 routed to port 0
      cfg_write(3, 2, 0);          // pipe 2 routed to port 0
      cfg_write(4, 2, 1);          // port 2 -> core 1
      m_glob = 2; m_common[0] = 3; m_common[3] = 0; m_pown[1] = 3;
      m_route[1] = 0; m_route[2] = 0; m_vown[2] = 1;

      @(negedge clk); cfg_lock = 1'b1;
      @(negedge clk); cfg_lock = 1'b0;
      check(cfg_locked == 1'b1, "R9", "cfg_locked after pulse", cfg_locked, 1);
      cfg_write(1, 0, 0);          // ignored after lock
      cfg_write(4, 0, 3);          // ignored after lock
      check(cfg_locked == 1'b1, "R9", "cfg_locked held", cfg_locked, 1);

      sweep(1);
      check_viol("sweep1");

      // a new refusal does not overwrite the record (R10)
      access(1, 4 * 16 + 7, 1'b1, 32'h1234);
      check_viol("no_overwrite");
      clear_core(1);
      access(1, 4 * 16 + 7, 1'b0, 32'h0);
      check_viol("after reclear");

      finish_run();
   end

endmodule